// File: doc/BRIEF.md
# Prioritized Five-Source Interrupt Controller

This block sits beside a small CPU core and merges five interrupt request lines into one pending request. The CPU sees which source is being requested and the restart vector address for it. One line is a non-maskable source. It needs both a rising edge and a line that is still high. One line is a rising-edge source with a sticky latch. Two lines are plain level sources. The last line is a general request that carries no internal vector. When several sources are pending, a fixed priority picks the winner.

The core controls the block with three strobes and one write port. An enable strobe sets a global enable flip-flop, and a disable strobe clears it. A mask write loads per-source mask bits from an 8-bit data byte. An 8-bit status word reports the pending state of the three maskable vectored sources, the enable flip-flop and the masks. An acknowledge input retires the request that is currently presented.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `req_o` is 0, `src_o` is 0, `vec_o` is 0, and `status_o` reads 8'h07: all three masks set, enable clear, nothing latched.
- R2: `src_o` encodes the winner as 0 none, 1 `nmi_i`, 2 `edge_i`, 3 `lvl_a_i`, 4 `lvl_b_i`, 5 `ext_i`. Priority runs from 1 (highest) to 5 (lowest). `req_o` is 1 exactly when `src_o` is non-zero.
- R3: The `nmi_i` source is recognised one clock after a rising edge, and only while the line stays high. It is presented regardless of the enable flip-flop and the masks.
- R4: A rising edge on `edge_i` sets a latch one clock later. The latch stays set after the line falls until that source is acknowledged or a mask write with bit 4 set clears it.
- R5: `lvl_a_i` and `lvl_b_i` are pending only while their line is high. Dropping the line withdraws the request in the same cycle.
- R6: `en_stb_i` sets the enable flip-flop and `dis_stb_i` clears it. When both are high, clear wins. While the flip-flop is clear, only the non-maskable source can be presented.
- R7: A mask write with bit 3 set loads the masks from bits 2, 1 and 0, which mask `edge_i`, `lvl_a_i` and `lvl_b_i` respectively (1 means masked). With bit 3 clear, the masks are unchanged. Bit 4 clears the edge latch whatever bit 3 holds. `ext_i` has no mask.
- R8: `vec_o` is the restart number times 8: 0x0024 for `nmi_i`, 0x003C for `edge_i`, 0x0034 for `lvl_a_i`, 0x002C for `lvl_b_i`, and 0 for `ext_i` or for no request.
- R9: The layout of `status_o` is: bit 6 the edge latch, bit 5 the `lvl_a_i` line, bit 4 the `lvl_b_i` line, bit 3 the enable flip-flop, bits 2:0 the masks, and bit 7 zero.
- R10: `ack_i` acts on the presented source. For the non-maskable source it clears that source's latch, so a new edge is needed. For any maskable source it clears the enable flip-flop. For `edge_i` it also clears the edge latch. With `req_o` low, `ack_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, edge plus level |
| edge_i | input | 1 | Rising-edge latched request |
| lvl_a_i | input | 1 | Level request, higher of the two |
| lvl_b_i | input | 1 | Level request, lower of the two |
| ext_i | input | 1 | General request, no vector |
| en_stb_i | input | 1 | Set the enable flip-flop |
| dis_stb_i | input | 1 | Clear the enable flip-flop |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | DATA_W | Mask write byte |
| ack_i | input | 1 | Acknowledge the presented request |
| req_o | output | 1 | A request is presented |
| src_o | output | 3 | Presented source code |
| vec_o | output | ADDR_W | Restart vector address |
| status_o | output | DATA_W | Mask and pending status word |

## Verification
The bench builds the block with its defaults: ADDR_W = 16, DATA_W = 8 and VEC_SCALE = 8. At this size every vector lands on its real address, and the whole state space is small enough to sweep. The sweep covers every combination of enable state, all eight mask values, edge latch set or clear, non-maskable held or idle, and all eight patterns of the three level and general lines. For each combination, the bench computes the winner and the vector by arithmetic. Directed sequences then cover the acknowledge paths, the enable and disable strobes arriving in the same cycle, mask writes with the update bit clear, and withdrawal of level and non-maskable requests.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int NUM_SRC  = 5;   // all request lines
  localparam int NUM_TRIG = 4;   // lines with a trigger stage
  localparam int NUM_VEC  = 4;   // lines carrying an internal vector
  localparam int NUM_MASK = 3;   // maskable vectored lines

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_EDGE = 3'd2,
    SRC_LVLA = 3'd3,
    SRC_LVLB = 3'd4,
    SRC_EXT  = 3'd5
  } irq_src_e;

  typedef enum logic [1:0] {
    TRIG_EDGE_LEVEL = 2'd0,
    TRIG_EDGE_HOLD  = 2'd1,
    TRIG_LEVEL      = 2'd2
  } trig_mode_e;

  // trigger style of source index idx (0 = highest priority)
  function automatic trig_mode_e mode_of(int idx);
    case (idx)
      0:       return TRIG_EDGE_LEVEL;
      1:       return TRIG_EDGE_HOLD;
      default: return TRIG_LEVEL;
    endcase
  endfunction

  // restart number in half steps (4.5 -> 9, 7.5 -> 15, ...)
  function automatic int unsigned half_restart(int idx);
    case (idx)
      0:       return 9;
      1:       return 15;
      2:       return 13;
      3:       return 11;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/irq_trig.sv
module irq_trig
  import irq_prio_pkg::*;
#(
  parameter trig_mode_e MODE = TRIG_LEVEL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clr_i,
  output logic req_o
);

  generate
    if (MODE == TRIG_LEVEL) begin : g_level
      logic unused_lvl;
      assign unused_lvl = ^{clk, rst_n, clr_i};
      assign req_o = line_i;
    end else begin : g_edge
      logic prev_q, pend_q, pend_d, rise;

      assign rise = line_i & ~prev_q;

      always_comb begin
        if (MODE == TRIG_EDGE_LEVEL) pend_d = line_i & (rise | (pend_q & ~clr_i));
        else                         pend_d = rise | (pend_q & ~clr_i);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= line_i;
          pend_q <= pend_d;
        end
      end

      if (MODE == TRIG_EDGE_LEVEL) begin : g_qual
        assign req_o = pend_q & line_i;
      end else begin : g_hold
        assign req_o = pend_q;
      end
    end
  endgenerate

endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_prio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_stb_i,
  input  logic                dis_stb_i,
  input  logic                ack_mask_i,
  input  logic                mask_ld_i,
  input  logic [NUM_MASK-1:0] mask_i,
  output logic                ie_o,
  output logic [NUM_MASK-1:0] mask_o
);

  logic                ie_q, ie_d, ie_en;
  logic [NUM_MASK-1:0] mask_q;

  assign ie_en = en_stb_i | dis_stb_i | ack_mask_i;

  always_comb begin
    ie_d = ie_q;
    if (dis_stb_i || ack_mask_i) ie_d = 1'b0;
    else if (en_stb_i)           ie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= 1'b0;
    else if (ie_en) ie_q <= ie_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '1;
    else if (mask_ld_i) mask_q <= mask_i;
  end

  assign ie_o   = ie_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int VEC_SCALE = 8
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output irq_src_e           src_o,
  output logic [ADDR_W-1:0]  vec_o
);

  logic [ADDR_W-1:0] vec_tab [NUM_SRC];

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_vec
      if (g < NUM_VEC) begin : g_has
        assign vec_tab[g] = ADDR_W'(half_restart(g) * VEC_SCALE / 2);
      end else begin : g_none
        assign vec_tab[g] = '0;
      end
    end
  endgenerate

  always_comb begin
    any_o = |req_i;
    src_o = SRC_NONE;
    vec_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        src_o = irq_src_e'(3'(i + 1));
        vec_o = vec_tab[i];
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int VEC_SCALE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic              edge_i,
  input  logic              lvl_a_i,
  input  logic              lvl_b_i,
  input  logic              ext_i,
  input  logic              en_stb_i,
  input  logic              dis_stb_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [2:0]        src_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [DATA_W-1:0] status_o
);

  localparam int BIT_LD  = NUM_MASK;      // mask update enable
  localparam int BIT_CLR = NUM_MASK + 1;  // edge latch clear
  localparam int ST_IE   = NUM_MASK;
  localparam int ST_PEND = NUM_MASK + 1;

  logic                rst_q_n;
  logic [NUM_TRIG-1:0] line, trig_req, trig_clr;
  logic [NUM_SRC-1:0]  eff_req;
  logic                ie;
  logic [NUM_MASK-1:0] mask;
  logic                any_req, ack_take, ack_mask, mask_ld, latch_clr;
  irq_src_e            src;

  irq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign line = {lvl_b_i, lvl_a_i, edge_i, nmi_i};

  assign ack_take  = ack_i & any_req;
  assign ack_mask  = ack_take & (src != SRC_NMI);
  assign mask_ld   = mask_wr_i & mask_wdata_i[BIT_LD];
  assign latch_clr = mask_wr_i & mask_wdata_i[BIT_CLR];

  always_comb begin
    trig_clr    = '0;
    trig_clr[0] = ack_take & (src == SRC_NMI);
    trig_clr[1] = (ack_take & (src == SRC_EDGE)) | latch_clr;
  end

  generate
    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
      irq_trig #(.MODE(mode_of(g))) u_trig (
        .clk    (clk),
        .rst_n  (rst_q_n),
        .line_i (line[g]),
        .clr_i  (trig_clr[g]),
        .req_o  (trig_req[g])
      );
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
      if (g == 0) begin : g_nm
        assign eff_req[g] = trig_req[g];
      end else if (g < NUM_TRIG) begin : g_mk
        assign eff_req[g] = trig_req[g] & ie & ~mask[NUM_MASK - g];
      end else begin : g_ext
        assign eff_req[g] = ext_i & ie;
      end
    end
  endgenerate

  irq_ctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .en_stb_i   (en_stb_i),
    .dis_stb_i  (dis_stb_i),
    .ack_mask_i (ack_mask),
    .mask_ld_i  (mask_ld),
    .mask_i     (mask_wdata_i[NUM_MASK-1:0]),
    .ie_o       (ie),
    .mask_o     (mask)
  );

  irq_arbiter #(.ADDR_W(ADDR_W), .VEC_SCALE(VEC_SCALE)) u_arb (
    .req_i (eff_req),
    .any_o (any_req),
    .src_o (src),
    .vec_o (vec_o)
  );

  always_comb begin
    status_o                          = '0;
    status_o[NUM_MASK-1:0]            = mask;
    status_o[ST_IE]                   = ie;
    status_o[ST_PEND+NUM_MASK-1:ST_PEND] = {trig_req[1], trig_req[2], trig_req[3]};
  end

  logic unused_wdata;
  assign unused_wdata = ^mask_wdata_i[DATA_W-1:BIT_CLR+1];

  assign req_o = any_req;
  assign src_o = src;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nmi_i,
  input logic              ack_i,
  input logic              en_stb_i,
  input logic              dis_stb_i,
  input logic              mask_wr_i,
  input logic [DATA_W-1:0] mask_wdata_i,
  input logic              req_o,
  input logic [2:0]        src_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic [DATA_W-1:0] status_o
);

  a_r2_req_matches_src: assert property (@(posedge clk) disable iff (!rst_n)
    req_o == (src_o != 3'd0));

  a_r3_nmi_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    (src_o == SRC_NMI) |-> nmi_i);

  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[6] && !ack_i && !(mask_wr_i && mask_wdata_i[4])) |=> status_o[6]);

  a_r6_off_only_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_o[3] && req_o) |-> (src_o == SRC_NMI));

  a_r6_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_stb_i && !dis_stb_i && !(ack_i && req_o && src_o != SRC_NMI)) |=> status_o[3]);

  a_r7_masked_edge_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[2] |-> (src_o != SRC_EDGE));

  a_r8_edge_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (src_o == SRC_EDGE) |-> (vec_o == ADDR_W'(60)));

  a_r10_ack_drops_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && req_o && src_o != SRC_NMI) |=> !status_o[3]);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .nmi_i        (nmi_i),
  .ack_i        (ack_i),
  .en_stb_i     (en_stb_i),
  .dis_stb_i    (dis_stb_i),
  .mask_wr_i    (mask_wr_i),
  .mask_wdata_i (mask_wdata_i),
  .req_o        (req_o),
  .src_o        (src_o),
  .vec_o        (vec_o),
  .status_o     (status_o)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n, nmi_i, edge_i, lvl_a_i, lvl_b_i, ext_i;
  logic en_stb_i, dis_stb_i, mask_wr_i, ack_i;
  logic [DATA_W-1:0] mask_wdata_i;
  logic req_o;
  logic [2:0] src_o;
  logic [ADDR_W-1:0] vec_o;
  logic [DATA_W-1:0] status_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .edge_i(edge_i),
    .lvl_a_i(lvl_a_i), .lvl_b_i(lvl_b_i), .ext_i(ext_i),
    .en_stb_i(en_stb_i), .dis_stb_i(dis_stb_i), .mask_wr_i(mask_wr_i),
    .mask_wdata_i(mask_wdata_i), .ack_i(ack_i), .req_o(req_o),
    .src_o(src_o), .vec_o(vec_o), .status_o(status_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic mask_write(input logic [7:0] d);
    mask_wr_i = 1'b1; mask_wdata_i = d;
    tick();
    mask_wr_i = 1'b0; mask_wdata_i = '0;
  endtask

  task automatic set_ie(input logic on);
    en_stb_i = on; dis_stb_i = ~on;
    tick();
    en_stb_i = 1'b0; dis_stb_i = 1'b0;
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1;
    tick();
    ack_i = 1'b0;
  endtask

  task automatic pulse_edge();
    edge_i = 1'b1; tick();
    edge_i = 1'b0; tick();
  endtask

  function automatic int exp_src(bit ie, bit [2:0] m, bit n, bit e, bit a, bit b, bit x);
    if (n) return 1;
    if (!ie) return 0;
    if (e && !m[2]) return 2;
    if (a && !m[1]) return 3;
    if (b && !m[0]) return 4;
    if (x) return 5;
    return 0;
  endfunction

  // vector = 8 * restart number; restart = (halfsteps)/2
  function automatic int exp_vec(int s);
    int half;
    case (s)
      1: half = 9;
      2: half = 15;
      3: half = 13;
      4: half = 11;
      default: half = 0;
    endcase
    return half * 8 / 2;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; nmi_i = 0; edge_i = 0; lvl_a_i = 0; lvl_b_i = 0; ext_i = 0;
    en_stb_i = 0; dis_stb_i = 0; mask_wr_i = 0; mask_wdata_i = '0; ack_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 req", int'(req_o), 0);
    chk("R1 src", int'(src_o), 0);
    chk("R1 vec", int'(vec_o), 0);
    chk("R1 status", int'(status_o), 'h07);

    // R2 R3 R4 R6 R7 R8 R9 sweep
    for (int ie = 0; ie < 2; ie++) begin
      for (int m = 0; m < 8; m++) begin
        for (int e = 0; e < 2; e++) begin
          for (int n = 0; n < 2; n++) begin
            for (int lv = 0; lv < 8; lv++) begin
              int s;
              mask_write(8'h18 | 8'(m));
              set_ie(ie[0]);
              if (e != 0) pulse_edge();
              if (n != 0) begin nmi_i = 1'b1; tick(); end
              lvl_a_i = lv[2]; lvl_b_i = lv[1]; ext_i = lv[0];
              #2;
              s = exp_src(ie[0], m[2:0], n[0], e[0], lv[2], lv[1], lv[0]);
              chk("R2 src", int'(src_o), s);
              chk("R2 req", int'(req_o), int'(s != 0));
              chk("R8 vec", int'(vec_o), exp_vec(s));
              chk("R9 status", int'(status_o),
                  (e << 6) | (lv[2] << 5) | (lv[1] << 4) | (ie << 3) | m);
              nmi_i = 0; lvl_a_i = 0; lvl_b_i = 0; ext_i = 0;
              tick();
            end
          end
        end
      end
    end

    // R5 level withdrawal
    mask_write(8'h18); set_ie(1'b1);
    lvl_a_i = 1'b1; #2;
    chk("R5 lvl_a on", int'(src_o), 3);
    lvl_a_i = 1'b0; #2;
    chk("R5 lvl_a off", int'(src_o), 0);

    // R3 needs line still high
    nmi_i = 1'b1; tick();
    chk("R3 nmi on", int'(src_o), 1);
    nmi_i = 1'b0; #2;
    chk("R3 nmi dropped", int'(req_o), 0);
    tick();

    // R10 nmi ack: latch cleared, ie untouched
    nmi_i = 1'b1; tick();
    pulse_ack();
    chk("R10 nmi ack req", int'(req_o), 0);
    chk("R10 nmi ack ie", int'(status_o[3]), 1);
    nmi_i = 1'b0; tick();

    // R10 level ack clears ie
    lvl_b_i = 1'b1; #2;
    chk("R10 lvl_b pre", int'(src_o), 4);
    pulse_ack();
    chk("R10 lvl ack ie", int'(status_o[3]), 0);
    chk("R10 lvl ack src", int'(src_o), 0);
    lvl_b_i = 1'b0;

    // R10 edge ack clears latch and ie
    set_ie(1'b1); pulse_edge();
    chk("R4 latch held", int'(status_o[6]), 1);
    pulse_ack();
    chk("R10 edge ack latch", int'(status_o[6]), 0);
    chk("R10 edge ack ie", int'(status_o[3]), 0);

    // R10 ack with no request is ignored
    set_ie(1'b1); pulse_ack();
    chk("R10 idle ack ie", int'(status_o[3]), 1);

    // R6 disable wins over enable
    en_stb_i = 1'b1; dis_stb_i = 1'b1; tick();
    en_stb_i = 1'b0; dis_stb_i = 1'b0;
    chk("R6 both strobes", int'(status_o[3]), 0);

    // R7 bit3 clear leaves masks; bit4 alone clears latch
    mask_write(8'h05);
    chk("R7 no load", int'(status_o[2:0]), 0);
    pulse_edge();
    chk("R4 latch set", int'(status_o[6]), 1);
    mask_write(8'h10);
    chk("R7 bit4 clear", int'(status_o[6]), 0);
    chk("R7 masks kept", int'(status_o[2:0]), 0);

    // R7 ext unaffected by masks
    mask_write(8'h0f); set_ie(1'b1);
    ext_i = 1'b1; #2;
    chk("R7 ext unmasked", int'(src_o), 5);
    chk("R8 ext vec", int'(vec_o), 0);
    ext_i = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule